// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that needs no idle cycle when the bus turns from reads to writes. Every command input is captured on the rising clock edge. That covers the three chip selects, the write strobe, the per-lane write strobes, the load/continue control and the address. Write data is taken one or two edges after its command, so the write latency always equals the read latency. A controller can therefore issue reads and writes in any mix on every cycle.

A run-time mode input chooses the timing. In pipelined timing both data latencies are two edges. In flow-through timing both are one edge. A two-bit burst counter produces follow-on addresses in either linear or interleaved order. A stall input freezes all internal state. An asynchronous output enable can silence the data bus at any time.

The data pins are presented pad-side: `dq_i` carries the sampled bus, `dq_o` carries the driven value, and `dq_oe` enables the pad driver. When `dq_oe` is low, the bus is high-Z.

Top module: `zt_sram`

## Requirements
- R1: A synchronous active-high `rst` empties both command stages, sets the burst step to 0 and makes the remembered command kind "deselect". `dq_oe` is low in the cycle after a reset edge. Memory contents are not changed by reset.
- R2: A new access is loaded only at an edge where `stall`=0 and `cont`=0. The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0, and any one of these three inactive makes the load a deselect. When selected, `wr_n`=1 means read and `wr_n`=0 means write, the full `addr` is used and the burst step restarts at 0.
- R3: With `flow_thru`=0, a read loaded at edge n drives `dq_o` = memory[address] with `dq_oe`=1 from edge n+1 until edge n+2.
- R4: With `flow_thru`=0, the data for a write loaded at edge n is taken from `dq_i` at edge n+2.
- R5: With `flow_thru`=1, a read loaded at edge n drives its data from edge n until edge n+1.
- R6: With `flow_thru`=1, the data for a write loaded at edge n is taken from `dq_i` at edge n+1.
- R7: At an enabled edge with `cont`=1, the block repeats the last loaded command kind (read, write or deselect) and ignores the three selects. The step goes up by 1 modulo 4, so it returns to the loaded address after four accesses. With `ilv_order`=0, address bits [1:0] are the start bits plus the step modulo 4, and the upper address bits are kept.
- R8: With `ilv_order`=1, address bits [1:0] of a continued access are the start bits XOR the step (start 01 gives 01, 00, 11, 10).
- R9: `lane_wr_n[i]`=0 writes bits [9i+8:9i] of the word, and the other lanes keep their old contents. A write whose lanes are all 1 is an abort: memory is left unchanged and the bus is not driven.
- R10: While `stall`=1, no stage, step or memory word changes. A read data phase keeps driving the same data, and a write data phase stays high-Z and takes its data at the next edge with `stall`=0.
- R11: `oe_n`=1 forces `dq_oe` low at once, without waiting for a clock. `dq_oe` is low in every write data phase.
- R12: A continue that follows a deselect is itself a deselect and never drives the bus. A continue that follows a read or a write extends that read or write.
- R13: Reads and writes may alternate on consecutive edges, in both modes, with no idle cycle, and each returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1 freezes all internal state for this edge |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| wr_n | input | 1 | 0 = write, 1 = read on a load |
| lane_wr_n | input | BYTES | Per-lane write strobes, active low |
| cont | input | 1 | 0 = load new access, 1 = continue burst |
| addr | input | ADDR_W | Word address for a load |
| flow_thru | input | 1 | 1 = flow-through timing, 0 = pipelined |
| ilv_order | input | 1 | 1 = interleaved burst order, 0 = linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | BYTES*BYTE_W | Data sampled from the bus |
| dq_o | output | BYTES*BYTE_W | Data driven onto the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
A command loaded at edge n has its data phase one edge later in flow-through timing and two edges later in pipelined timing. Read data must be on the bus in that phase cycle, and write data is taken at the edge that closes the phase. Every stall edge pushes both of these later by one. The bench gives each cycle its own stimulus at the falling edge and samples `dq_oe`/`dq_o` one nanosecond later, before the next rising edge. Each table row carries a hand-derived expected bus direction for the phase landing in that cycle, which fixes the latency independently. A reference memory, updated only at the enabled edge that closes a write phase, supplies the expected read data.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Kind of access held in a command stage or remembered for bursts.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_burst_order.sv
// Low address bits of a burst access from the start bits and the step.
module zt_burst_order #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_lsb,
    input  logic [CNT_W-1:0] step,
    input  logic             interleave,
    output logic [CNT_W-1:0] lsb
);

    logic [CNT_W-1:0] lin_lsb;
    logic [CNT_W-1:0] ilv_lsb;

    assign lin_lsb = start_lsb + step;
    assign ilv_lsb = start_lsb ^ step;
    assign lsb     = interleave ? ilv_lsb : lin_lsb;

endmodule

// File: rtl/zt_sram_array.sv
// Storage split into independent byte lanes; asynchronous read port.
module zt_sram_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTES-1:0]          wr_mask,
    input  logic [BYTES*BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTES*BYTE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar ln = 0; ln < BYTES; ln++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[ln]) begin
                lane_mem[wr_addr] <= wr_data[ln*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[ln*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stall,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    wr_n,
    input  logic [BYTES-1:0]        lane_wr_n,
    input  logic                    cont,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    flow_thru,
    input  logic                    ilv_order,
    input  logic                    oe_n,
    input  logic [BYTES*BYTE_W-1:0] dq_i,
    output logic [BYTES*BYTE_W-1:0] dq_o,
    output logic                    dq_oe
);

    localparam int DATA_W = BYTES * BYTE_W;
    localparam int STEP_W = 2;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  mask;
    } stage_t;

    typedef struct packed {
        stage_t            s1;     // command registered at the last edge
        stage_t            s2;     // command one edge older
        op_e               last;   // kind repeated by a continue
        logic [ADDR_W-1:0] base;   // address of the last load
        logic [STEP_W-1:0] step;   // burst position
    } state_t;

    state_t st_d, st_q;

    logic              chip_sel;
    logic [STEP_W-1:0] step_nx;
    logic [STEP_W-1:0] start_lsb;
    logic [STEP_W-1:0] use_step;
    logic [STEP_W-1:0] lsb_nx;
    stage_t            ph;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic [STEP_W-1:0] burst_step_q;

    assign chip_sel  = !sel_a_n && sel_b && !sel_c_n;
    assign step_nx   = st_q.step + 2'd1;
    assign start_lsb = cont ? st_q.base[STEP_W-1:0] : addr[STEP_W-1:0];
    assign use_step  = cont ? step_nx : '0;

    zt_burst_order #(.CNT_W(STEP_W)) u_order (
        .start_lsb  (start_lsb),
        .step       (use_step),
        .interleave (ilv_order),
        .lsb        (lsb_nx)
    );

    // Stage whose data phase is the current cycle.
    assign ph = flow_thru ? st_q.s1 : st_q.s2;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!stall) begin
            st_d.s2 = st_q.s1;
            if (cont) begin
                st_d.step    = step_nx;
                st_d.s1.op   = st_q.last;
                st_d.s1.addr = {st_q.base[ADDR_W-1:STEP_W], lsb_nx};
            end else begin
                st_d.step    = '0;
                st_d.base    = addr;
                st_d.s1.op   = chip_sel ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
                st_d.s1.addr = {addr[ADDR_W-1:STEP_W], lsb_nx};
                st_d.last    = st_d.s1.op;
            end
            st_d.s1.mask = (st_d.s1.op == OP_WRITE) ? ~lane_wr_n : '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_en = !rst && !stall && (ph.op == OP_WRITE);

    zt_sram_array #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (ph.addr),
        .wr_mask (ph.mask),
        .wr_data (dq_i),
        .rd_addr (ph.addr),
        .rd_data (rd_data)
    );

    assign dq_o         = rd_data;
    assign dq_oe        = (ph.op == OP_READ) && !oe_n;
    assign burst_step_q = st_q.step;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk (
    input logic       clk,
    input logic       rst,
    input logic       stall,
    input logic       cont,
    input logic       sel_a_n,
    input logic       sel_b,
    input logic       sel_c_n,
    input logic       wr_n,
    input logic       flow_thru,
    input logic       oe_n,
    input logic       dq_oe,
    input logic [1:0] step_q
);

    logic sel;
    assign sel = !sel_a_n && sel_b && !sel_c_n;

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !dq_oe);

    assert_load_clears_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !cont) |=> (step_q == 2'd0));

    assert_pipe_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        ((!stall && !cont && sel && wr_n && !flow_thru) ##1 (!stall && !flow_thru))
        |=> (dq_oe || oe_n || flow_thru));

    assert_flow_read_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (!stall && !cont && sel && wr_n && flow_thru) |=> (dq_oe || oe_n || !flow_thru));

    assert_step_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall && cont) |=> (step_q == $past(step_q) + 2'd1));

    assert_stall_holds_step_R10: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(step_q));

    assert_stall_keeps_drive_R10: assert property (@(posedge clk) disable iff (rst)
        (stall && dq_oe) |=> (dq_oe || oe_n));

    assert_write_phase_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!stall && !cont && sel && !wr_n && flow_thru) |=> (!dq_oe || !flow_thru));

endmodule

bind zt_sram zt_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .cont      (cont),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .wr_n      (wr_n),
    .flow_thru (flow_thru),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .step_q    (burst_step_q)
);

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    // select patterns {sel_a_n, sel_b, sel_c_n}
    localparam logic [2:0] SL = 3'b010;
    localparam logic [2:0] N1 = 3'b110;
    localparam logic [2:0] N2 = 3'b000;
    localparam logic [2:0] N3 = 3'b011;

    // row: {flow, ilv, cont, sel[2:0], wr_n, lane_wr_n[3:0], addr[7:0], exp[1:0]}
    // exp = bus direction of the data phase in this row: 0 idle, 1 driven, 2 write
    localparam int NV = 38;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h10,2'd0},
        {1'b0,1'b0,1'b0,SL,1'b0,4'h0,8'h11,2'd0},
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h11,2'd1},
        {1'b0,1'b0,1'b0,SL,1'b0,4'hA,8'h10,2'd2},
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h10,2'd1},
        {1'b0,1'b0,1'b0,SL,1'b0,4'hF,8'h12,2'd2},
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h12,2'd1},
        {1'b0,1'b0,1'b0,N1,1'b1,4'hF,8'h00,2'd2},
        {1'b0,1'b0,1'b1,N2,1'b1,4'hF,8'h00,2'd1},
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h22,2'd0},
        {1'b0,1'b0,1'b1,SL,1'b1,4'hF,8'h00,2'd0},
        {1'b0,1'b0,1'b1,SL,1'b1,4'hF,8'h00,2'd1},
        {1'b0,1'b0,1'b1,SL,1'b1,4'hF,8'h00,2'd1},
        {1'b0,1'b0,1'b1,SL,1'b1,4'hF,8'h00,2'd1},
        {1'b0,1'b0,1'b0,SL,1'b0,4'h0,8'h35,2'd1},
        {1'b0,1'b0,1'b1,N2,1'b0,4'h0,8'h00,2'd1},
        {1'b0,1'b0,1'b1,SL,1'b0,4'h7,8'h00,2'd2},
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h36,2'd2},
        {1'b0,1'b0,1'b0,SL,1'b1,4'hF,8'h37,2'd2},
        {1'b0,1'b0,1'b0,N3,1'b1,4'hF,8'h00,2'd1},
        {1'b0,1'b0,1'b0,N2,1'b1,4'hF,8'h00,2'd1},
        {1'b1,1'b1,1'b0,SL,1'b1,4'hF,8'h41,2'd0},
        {1'b1,1'b1,1'b1,SL,1'b1,4'hF,8'h00,2'd1},
        {1'b1,1'b1,1'b1,SL,1'b1,4'hF,8'h00,2'd1},
        {1'b1,1'b1,1'b1,SL,1'b1,4'hF,8'h00,2'd1},
        {1'b1,1'b1,1'b0,SL,1'b0,4'h0,8'h41,2'd1},
        {1'b1,1'b1,1'b0,SL,1'b1,4'hF,8'h41,2'd2},
        {1'b1,1'b1,1'b0,SL,1'b0,4'hC,8'h40,2'd1},
        {1'b1,1'b1,1'b0,SL,1'b1,4'hF,8'h40,2'd2},
        {1'b1,1'b1,1'b0,SL,1'b0,4'h0,8'h52,2'd1},
        {1'b1,1'b1,1'b1,SL,1'b0,4'h0,8'h00,2'd2},
        {1'b1,1'b1,1'b1,SL,1'b0,4'h0,8'h00,2'd2},
        {1'b1,1'b1,1'b0,N1,1'b1,4'hF,8'h00,2'd2},
        {1'b1,1'b1,1'b0,SL,1'b1,4'hF,8'h52,2'd0},
        {1'b1,1'b1,1'b0,SL,1'b1,4'hF,8'h53,2'd1},
        {1'b1,1'b1,1'b0,SL,1'b1,4'hF,8'h50,2'd1},
        {1'b1,1'b1,1'b0,N3,1'b1,4'hF,8'h00,2'd1},
        {1'b1,1'b1,1'b0,N2,1'b1,4'hF,8'h00,2'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [NB-1:0] lane_wr_n = '1;
    logic          cont = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          flow_thru = 1'b0;
    logic          ilv_order = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut (
        .clk(clk), .rst(rst), .stall(stall),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_n(wr_n), .lane_wr_n(lane_wr_n), .cont(cont), .addr(addr),
        .flow_thru(flow_thru), .ilv_order(ilv_order), .oe_n(oe_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference memory and command model (ops: 0 idle, 1 read, 2 write)
    logic [DW-1:0] ref_mem [1 << AW];
    int            m1_op = 0, m2_op = 0, m_last = 0;
    logic [AW-1:0] m1_a = '0, m2_a = '0, m_base = '0;
    logic [NB-1:0] m1_m = '0, m2_m = '0;
    logic [1:0]    m_step = '0;

    function automatic logic [DW-1:0] pat(input int c);
        logic [8:0] k;
        k = c[8:0];
        return {k + 9'd3, k ^ 9'h0AA, ~k, k + 9'd77};
    endfunction

    function automatic string row_tag(input int r);
        if (r <= 8)  return "R2 R3 R4 R9 R12 R13";
        if (r <= 20) return "R7 R3 R4";
        if (r <= 24) return "R8 R5";
        return "R6 R8 R9 R13";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, expv);
        end
    endtask

    task automatic model_reset();
        m1_op = 0; m2_op = 0; m_last = 0;
        m1_a = '0; m2_a = '0; m_base = '0;
        m1_m = '0; m2_m = '0; m_step = '0;
    endtask

    // One cycle: drive at the falling edge, check 1 ns later, then one rising edge.
    task automatic step(input bit fl, input bit il, input bit st, input bit cn,
                        input logic [2:0] sl, input bit wn, input logic [NB-1:0] bn,
                        input logic [AW-1:0] a, input bit oe, input int expk,
                        input string tag);
        int            pop;
        logic [AW-1:0] pa;
        logic [NB-1:0] pm;
        bit            exp_oe;
        pop = fl ? m1_op : m2_op;
        pa  = fl ? m1_a  : m2_a;
        pm  = fl ? m1_m  : m2_m;
        rst = 1'b0; flow_thru = fl; ilv_order = il; stall = st; cont = cn;
        sel_a_n = sl[2]; sel_b = sl[1]; sel_c_n = sl[0];
        wr_n = wn; lane_wr_n = bn; addr = a; oe_n = oe;
        dq_i = pat(cyc);
        #1;
        exp_oe = (expk == 3) ? (pop == 1 && !oe) : (expk == 1 && !oe);
        chk(dq_oe == exp_oe, {tag, " bus direction"}, DW'(dq_oe), DW'(exp_oe));
        if (exp_oe) chk(dq_o == ref_mem[pa], {tag, " read data"}, dq_o, ref_mem[pa]);
        @(posedge clk);
        if (!st) begin
            if (pop == 2) begin
                for (int b = 0; b < NB; b++)
                    if (pm[b]) ref_mem[pa][b*BW +: BW] = dq_i[b*BW +: BW];
            end
            m2_op = m1_op; m2_a = m1_a; m2_m = m1_m;
            if (cn) begin
                m_step = m_step + 2'd1;
                m1_op  = m_last;
                m1_a   = {m_base[AW-1:2], il ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step)};
            end else begin
                m_step = '0;
                m_base = a;
                m1_op  = (sl == SL) ? (wn ? 1 : 2) : 0;
                m_last = m1_op;
                m1_a   = a;
            end
            m1_m = (m1_op == 2) ? ~bn : '0;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; stall = 1'b0; cont = 1'b0;
        @(posedge clk);
        model_reset();
        cyc++;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [20:0] v;
        @(negedge clk);
        do_reset();
        do_reset();
        #1;
        // R1: bus released after reset
        chk(dq_oe == 1'b0, "R1 reset idle", DW'(dq_oe), '0);

        // fill every word with back-to-back pipelined writes (R4, R13)
        for (int i = 0; i < (1 << AW); i++)
            step(0, 0, 0, 0, SL, 0, 4'h0, AW'(i), 0, 3, "R4 fill");
        step(0, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 3, "R2 drain");
        step(0, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 3, "R2 drain");

        // vector table: alternating reads/writes, bursts, lanes, aborts
        for (int r = 0; r < NV; r++) begin
            v = VEC[r];
            step(v[20], v[19], 1'b0, v[18], v[17:15], v[14], v[13:10], v[9:2],
                 1'b0, int'(v[1:0]), row_tag(r));
        end

        // R10 R11: stall during a pipelined read phase, async output enable
        step(0, 0, 0, 0, SL, 1, 4'hF, 8'h60, 0, 0, "R3 load");
        step(0, 0, 1, 0, SL, 1, 4'hF, 8'h61, 0, 0, "R10 stall before phase");
        step(0, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 0, "R10 resume");
        step(0, 0, 1, 0, SL, 0, 4'h0, 8'h61, 0, 1, "R10 stall keeps drive");
        step(0, 0, 1, 0, SL, 0, 4'h0, 8'h61, 1, 0, "R11 oe_n high");
        step(0, 0, 1, 0, SL, 0, 4'h0, 8'h61, 0, 1, "R11 oe_n low again");
        step(0, 0, 0, 0, N2, 1, 4'hF, 8'h00, 0, 1, "R10 phase completes");
        step(0, 0, 0, 0, N2, 1, 4'hF, 8'h00, 0, 0, "R3 idle");

        // R10: stall during a pipelined write phase, data taken at the enabled edge
        step(0, 0, 0, 0, SL, 0, 4'h0, 8'h61, 0, 0, "R4 write load");
        step(0, 0, 0, 0, N3, 1, 4'hF, 8'h00, 0, 0, "R4 gap");
        step(0, 0, 1, 0, SL, 1, 4'hF, 8'h61, 0, 2, "R10 stalled write phase");
        step(0, 0, 1, 0, SL, 1, 4'hF, 8'h61, 0, 2, "R10 stalled write phase");
        step(0, 0, 0, 0, SL, 1, 4'hF, 8'h61, 0, 2, "R10 write taken");
        step(0, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 0, "R10 idle");
        step(0, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 1, "R10 R4 readback");

        // R6 R10: flow-through write with stalls
        step(1, 0, 0, 0, SL, 0, 4'h5, 8'h62, 0, 0, "R6 write load");
        step(1, 0, 1, 0, N1, 1, 4'hF, 8'h00, 0, 2, "R10 flow stall");
        step(1, 0, 0, 0, SL, 1, 4'hF, 8'h62, 0, 2, "R6 write taken");
        step(1, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 1, "R6 R9 readback");
        step(1, 0, 0, 0, N1, 1, 4'hF, 8'h00, 0, 0, "R5 idle");

        // R1 R12: reset in the middle of a read burst, then a continue
        step(0, 0, 0, 0, SL, 1, 4'hF, 8'h70, 0, 0, "R3 burst load");
        step(0, 0, 0, 1, SL, 1, 4'hF, 8'h00, 0, 0, "R7 burst");
        do_reset();
        step(0, 0, 0, 1, SL, 1, 4'hF, 8'h00, 0, 0, "R1 after reset");
        step(0, 0, 0, 1, SL, 1, 4'hF, 8'h00, 0, 0, "R12 continue after reset");
        step(0, 0, 0, 0, N2, 1, 4'hF, 8'h00, 0, 0, "R12 no drive");
        step(0, 0, 0, 0, N2, 1, 4'hF, 8'h00, 0, 0, "R12 no drive");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule